// File: doc/BRIEF.md
# Shadow-Backed SRAM with Bulk Store and Recall

This block is a 512-word by 8-bit working RAM in which each word is paired with a nonvolatile shadow word. A level-sensitive mode input chooses between two kinds of use. With the mode input low, the block acts as a synchronous RAM with chip-select, output-enable and write-enable controls. With the mode input high, RAM access is shut off and the block can run a bulk transfer in one of two directions. A store copies the whole working array into the shadow. A recall first clears the working array and then loads it from the shadow.

Each transfer starts on a rising edge of a start strobe, and a direction input picks the operation. A busy output stays high for the whole transfer. Each transfer direction has its own parameter for its length in clock cycles. Releasing reset stands in for power-up, and it starts an automatic recall. As a result, contents saved by an earlier store come back after each reset.

Top module: `nvs_store_recall`

## Requirements
- R1: In SRAM mode, a write at an address followed by a read of that address returns the written byte, for all 512 addresses. Read data and its valid flag are registered, so they appear one clock after the read is presented.
- R2: `rd_valid` is 1 in a cycle only when the previous cycle had `sel`=1, `out_en`=1, `wr_en`=0, `nv_mode`=0 and `busy`=0. When `rd_valid` is 0, `rd_data` is 0.
- R3: A write takes effect on a clock edge where `sel`=1 and `wr_en`=1 in SRAM mode. When `out_en` is also 1, the write still happens and no read data is produced.
- R4: While `nv_mode`=1, reads give no valid data and writes leave the working array unchanged.
- R5: A store (`xfer_dir`=1) copies all 512 working words into the shadow. `busy` is high for exactly STORE_CYCLES cycles after the edge that accepts the start.
- R6: A recall (`xfer_dir`=0) runs a clear phase and then a load phase. Afterwards the working array equals the shadow. `busy` is high for exactly RECALL_CYCLES cycles.
- R7: A recall never changes the shadow array, so repeated recalls return the same contents.
- R8: When reset is released, an automatic recall runs. `busy` is high for RECALL_CYCLES cycles, and the working array then holds the shadow contents.
- R9: A transfer starts only on a rising edge of `xfer_go` sampled while `nv_mode`=1 and `busy`=0. A rising edge while busy, or one in SRAM mode, is ignored.
- R10: While `busy`=1, no read data is produced and no write reaches the working array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release starts an automatic recall |
| nv_mode | input | 1 | 1 selects transfer mode, 0 selects SRAM mode |
| xfer_go | input | 1 | Start strobe, acts on its rising edge |
| xfer_dir | input | 1 | 1 selects store, 0 selects recall |
| sel | input | 1 | Chip select |
| out_en | input | 1 | Output enable |
| wr_en | input | 1 | Write enable |
| addr | input | 9 | Word address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, 0 when not valid |
| rd_valid | output | 1 | Read data valid |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest property to show from the ports is that the shadow survives a recall and a reset, because the shadow can only be seen through a later recall. The bench fills the array with one pattern and stores it. It then writes the complement everywhere and recalls, and sweeps all addresses to expect the first pattern. It then overwrites the array again, pulses reset, and expects the automatic recall to restore the first pattern once more. A second start strobe is raised partway through a store, and the length of the busy window shows whether that strobe was ignored.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    localparam int WORDS  = 512;
    localparam int AW     = 9;
    localparam int DW     = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_CLEAR = 2'd2,
        ST_LOAD  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic do_store;
        logic do_clear;
        logic do_load;
    } xfer_cmd_t;

    typedef struct packed {
        logic          rd;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } port_req_t;

    function automatic logic is_transfer(input seq_state_e s);
        return s != ST_IDLE;
    endfunction
endpackage

// File: rtl/nvs_port.sv
module nvs_port
    import nvs_pkg::*;
(
    input  logic          nv_mode,
    input  logic          busy,
    input  logic          sel,
    input  logic          out_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output port_req_t     req
);
    logic open_ok;

    always_comb begin
        open_ok  = !nv_mode && !busy && sel;
        req.wr   = open_ok && wr_en;
        req.rd   = open_ok && out_en && !wr_en;
        req.addr = addr;
        req.data = wr_data;
    end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int STORE_CYCLES  = 40,
    parameter int RECALL_CYCLES = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      nv_mode,
    input  logic      xfer_go,
    input  logic      xfer_dir,
    output xfer_cmd_t cmd,
    output logic      busy
);
    localparam int MAXC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] STORE_LAST = CW'(STORE_CYCLES - 1);
    localparam logic [CW-1:0] LOAD_LAST  = CW'(RECALL_CYCLES - 2);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic          go_q;
    logic          start;

    assign start = xfer_go && !go_q && nv_mode && (state == ST_IDLE);
    assign busy  = is_transfer(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CLEAR;
            cnt   <= '0;
            go_q  <= 1'b0;
        end else begin
            go_q <= xfer_go;
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) state <= xfer_dir ? ST_STORE : ST_CLEAR;
                end
                ST_STORE: begin
                    if (cnt == STORE_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CLEAR: begin
                    state <= ST_LOAD;
                    cnt   <= '0;
                end
                ST_LOAD: begin
                    if (cnt == LOAD_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd.do_store = (state == ST_STORE) && (cnt == STORE_LAST);
        cmd.do_clear = (state == ST_CLEAR);
        cmd.do_load  = (state == ST_LOAD) && (cnt == LOAD_LAST);
    end

    // R6
    load_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |-> ($past(state) == ST_CLEAR || $past(state) == ST_LOAD));

    // R5
    store_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STORE && cnt != STORE_LAST) |=> (state == ST_STORE && busy));

    // R9
    start_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_IDLE && state != ST_IDLE) |-> $past(nv_mode) && $rose(go_q));

    // R6
    one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.do_store, cmd.do_clear, cmd.do_load}));

    initial begin
        // R6
        recall_len_chk: assert (RECALL_CYCLES >= 2 && STORE_CYCLES >= 1);
    end
endmodule

// File: rtl/nvs_array.sv
module nvs_array
    import nvs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  xfer_cmd_t     cmd,
    input  port_req_t     req,
    input  logic          busy,
    input  logic          nv_mode,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [DW-1:0] work   [WORDS];
    logic [DW-1:0] shadow [WORDS];
    logic [DW-1:0] shadow_probe;

    assign shadow_probe = shadow[req.addr];

    always_ff @(posedge clk) begin
        if (cmd.do_clear) begin
            for (int i = 0; i < WORDS; i++) work[i] <= '0;
        end else if (cmd.do_load) begin
            for (int i = 0; i < WORDS; i++) work[i] <= shadow[i];
        end else if (req.wr) begin
            work[req.addr] <= req.data;
        end
    end

    always_ff @(posedge clk) begin
        if (cmd.do_store) begin
            for (int i = 0; i < WORDS; i++) shadow[i] <= work[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req.rd;
            rd_data  <= req.rd ? work[req.addr] : '0;
        end
    end

    // R10
    busy_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rd_valid);

    // R4
    mode_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
        nv_mode |=> !rd_valid);

    // R3
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        req.wr |=> !rd_valid);

    // R2
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == '0);

    // R7
    shadow_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cmd.do_store) && $stable(req.addr)) |-> $stable(shadow_probe));
endmodule

// File: rtl/nvs_store_recall.sv
module nvs_store_recall
    import nvs_pkg::*;
#(
    parameter int STORE_CYCLES  = 40,
    parameter int RECALL_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nv_mode,
    input  logic          xfer_go,
    input  logic          xfer_dir,
    input  logic          sel,
    input  logic          out_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          busy
);
    xfer_cmd_t cmd;
    port_req_t req;

    nvs_seq #(
        .STORE_CYCLES (STORE_CYCLES),
        .RECALL_CYCLES(RECALL_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .nv_mode (nv_mode),
        .xfer_go (xfer_go),
        .xfer_dir(xfer_dir),
        .cmd     (cmd),
        .busy    (busy)
    );

    nvs_port u_port (
        .nv_mode(nv_mode),
        .busy   (busy),
        .sel    (sel),
        .out_en (out_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .req    (req)
    );

    nvs_array u_array (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .req     (req),
        .busy    (busy),
        .nv_mode (nv_mode),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    // R1
    valid_needs_prior_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(sel) && $past(out_en) && !$past(wr_en) && !$past(nv_mode));
endmodule

// File: tb/nvs_store_recall_test.sv
`timescale 1ns/1ps
module nvs_store_recall_test;
    localparam int SC = 12;
    localparam int RC = 5;
    localparam int N  = 512;

    logic       clk = 1'b0;
    logic       rst, nv_mode, xfer_go, xfer_dir, sel, out_en, wr_en;
    logic [8:0] addr;
    logic [7:0] wr_data, rd_data;
    logic       rd_valid, busy;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    nvs_store_recall #(.STORE_CYCLES(SC), .RECALL_CYCLES(RC)) uut (
        .clk(clk), .rst(rst), .nv_mode(nv_mode), .xfer_go(xfer_go),
        .xfer_dir(xfer_dir), .sel(sel), .out_en(out_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy));

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sel = 0; out_en = 0; wr_en = 0; xfer_go = 0;
    endtask

    task automatic write_word(input int a, input logic [7:0] d);
        sel = 1; wr_en = 1; out_en = 0; addr = 9'(a); wr_data = d;
        @(negedge clk);
        idle_inputs();
    endtask

    // presents a read at a negedge, samples the registered result one edge later
    task automatic read_word(input int a, output logic v, output logic [7:0] d);
        sel = 1; out_en = 1; wr_en = 0; addr = 9'(a);
        @(negedge clk);
        v = rd_valid; d = rd_data;
        idle_inputs();
    endtask

    task automatic sweep_expect(input string req, input bit inv);
        int bad = 0;
        logic v; logic [7:0] d;
        for (int a = 0; a < N; a++) begin
            read_word(a, v, d);
            if (!v || d != (inv ? ~pat(a) : pat(a))) begin
                if (bad == 0) check(req, int'(d), int'(inv ? ~pat(a) : pat(a)));
                bad++;
            end
        end
        if (bad == 0) check(req, 0, 0);
    endtask

    task automatic fill(input bit inv);
        for (int a = 0; a < N; a++) write_word(a, inv ? ~pat(a) : pat(a));
    endtask

    // strobes a start; returns how many negedge samples show busy high
    task automatic run_xfer(input logic dir, input bit poke, output int len);
        nv_mode = 1; xfer_dir = dir; xfer_go = 1;
        @(negedge clk);
        xfer_go = 0;
        len = 0;
        while (busy && len < 1000) begin
            len++;
            if (poke) xfer_go = (len == 3);
            @(negedge clk);
        end
        xfer_go = 0;
        nv_mode = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        int len;
        logic v; logic [7:0] d;
        rst = 1; nv_mode = 0; xfer_dir = 0; addr = '0; wr_data = '0;
        idle_inputs();
        @(negedge clk);
        check("R2 reset valid", int'(rd_valid), 0);
        check("R8 busy in reset", int'(busy), 1);
        repeat (2) @(negedge clk);
        rst = 0;
        len = 0;
        while (busy && len < 1000) begin len++; @(negedge clk); end
        check("R8 auto recall length", len, RC);

        // R1 sweep
        fill(0);
        sweep_expect("R1 write/read sweep", 0);

        // R2 gating
        sel = 0; out_en = 1; addr = 9'd7; @(negedge clk);
        check("R2 no sel", int'(rd_valid), 0);
        check("R2 no sel data", int'(rd_data), 0);
        idle_inputs();
        sel = 1; out_en = 0; addr = 9'd7; @(negedge clk);
        check("R2 no out_en", int'(rd_valid), 0);
        idle_inputs();

        // R3 write with out_en high
        sel = 1; out_en = 1; wr_en = 1; addr = 9'd9; wr_data = 8'hA5; @(negedge clk);
        check("R3 write priority no valid", int'(rd_valid), 0);
        idle_inputs();
        read_word(9, v, d);
        check("R3 write priority data", int'(d), 8'hA5);
        write_word(9, pat(9));

        // R4 nv mode blocks access
        nv_mode = 1;
        read_word(20, v, d);
        check("R4 read in nv mode", int'(v), 0);
        write_word(20, 8'h00);
        nv_mode = 0;
        read_word(20, v, d);
        check("R4 write ignored in nv mode", int'(d), int'(pat(20)));

        // R9 start in SRAM mode ignored
        xfer_dir = 1; xfer_go = 1; @(negedge clk); xfer_go = 0; @(negedge clk);
        check("R9 start in SRAM mode", int'(busy), 0);

        // R5 store with second strobe mid-way (R9, R10)
        run_xfer(1'b1, 1'b1, len);
        check("R5 store busy length, R9 strobe ignored", len, SC);
        @(negedge clk);
        check("R9 no restart after store", int'(busy), 0);

        // R6 recall restores stored pattern
        fill(1);
        sweep_expect("R1 complement sweep", 1);
        run_xfer(1'b0, 1'b0, len);
        check("R6 recall busy length", len, RC);
        sweep_expect("R6 recall contents", 0);

        // R10 write during recall blocked
        nv_mode = 1; xfer_dir = 0; xfer_go = 1; @(negedge clk); xfer_go = 0;
        nv_mode = 0;
        write_word(30, 8'h3C);
        read_word(31, v, d);
        check("R10 read blocked while busy", int'(v), 0);
        repeat (RC + 2) @(negedge clk);
        read_word(30, v, d);
        check("R10 write blocked while busy", int'(d), int'(pat(30)));

        // R7 repeated recall leaves shadow
        fill(1);
        run_xfer(1'b0, 1'b0, len);
        run_xfer(1'b0, 1'b0, len);
        check("R7 second recall length", len, RC);
        sweep_expect("R7 shadow kept", 0);

        // R8 reset restores shadow
        fill(1);
        do_reset();
        len = 0;
        while (busy && len < 1000) begin len++; @(negedge clk); end
        check("R8 recall after reset length", len, RC);
        sweep_expect("R8 contents after reset", 0);

        done = 1'b1;
        finish_up();
    end
endmodule